// File: doc/BRIEF.md
# Seconds Counter with Coherent Snapshot Readout

This block keeps elapsed time as a binary count of seconds. A prescaler takes a 32.768 kHz clock enable and produces one tick per second. Each tick advances a counter that wraps silently at its top value. Software reaches the counter through a byte-wide register port. A read of the lowest byte freezes a full copy of the count, so the remaining bytes come from that copy while the live counter keeps running. Writes are gathered byte by byte and take effect together when the top byte arrives.

Loading a new time also restarts the slow tail of the prescaler, so the next second is counted from the moment of the load. The few fast front stages of the prescaler are never cleared. A square-wave output can show the 1 Hz phase of the tail or one of the faster rates taken from the front. The 1 Hz wave is re-phased by a load; the faster waves are not disturbed by it.

Top module: `rtc_seconds`

## Requirements
- R1: The counter advances by exactly one on each second tick. A tick occurs on the clock enable that brings the prescaler from DIV-1 back to 0, where DIV is the division ratio (32768 by default). Without a tick or a load, the counter holds its value.
- R2: A tick at the all-ones count yields zero on the next cycle, with no other indication.
- R3: A read strobe at address 0 returns the live bits 7:0 and copies the whole live count into a snapshot. A read at address k>0 returns snapshot bits 8k+7:8k, even if the counter has moved on since. Read data appears one clock after the strobe and holds until the next read.
- R4: Write strobes at addresses below the top byte address (3 by default) only stage their byte, and the counter is not changed. A write at the top address loads the counter with {top byte, staged byte 2, staged byte 1, staged byte 0}. That load takes priority over a tick in the same cycle.
- R5: A load clears the prescaler tail, which is every stage above the lowest FRONT_W bits (3 by default). The following tick comes DIV minus the front-stage count enables later.
- R6: The front stages are never cleared by a load. They count clock enables modulo 2^FRONT_W from reset.
- R7: The square-wave select codes are: 0 = 1 Hz (top prescaler bit), 1 = 4.096 kHz (prescaler bit 2), 2 = 8.192 kHz (prescaler bit 1), 3 = 32.768 kHz (the clock enable delayed by one clock). The 1 Hz wave is low in the first half of each second and is forced low by a load.
- R8: While the square-wave enable is low, the square-wave output is 0.
- R9: After reset, the count, prescaler, snapshot, read data and square-wave output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse at 32.768 kHz |
| rd_stb | input | 1 | Register read strobe |
| wr_stb | input | 1 | Register write strobe |
| addr | input | AW | Byte address, 0 = least significant |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid one cycle after rd_stb |
| sq_en | input | 1 | Square-wave enable |
| sq_sel | input | 2 | Square-wave rate select |
| sq_out | output | 1 | Square-wave output |

## Verification
The bench builds the block with DIV = 64 and FRONT_W = 3, keeping the counter at 32 bits. A second then lasts only 64 enables, so many ticks, the all-ones wrap and several load-to-tick distances fit in a short run. The square-wave output is compared on every cycle against a prescaler modelled arithmetically. This covers all four rates, with the enable on and off, under several enable spacings, and with loads dropped into the middle of a second.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
   typedef enum logic [1:0] {
      SQ_SEC  = 2'd0,
      SQ_4K   = 2'd1,
      SQ_8K   = 2'd2,
      SQ_OSC  = 2'd3
   } sq_rate_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned TAP_4K = 2;
   localparam int unsigned TAP_8K = 1;
endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
   parameter int unsigned P_W     = 15,
   parameter int unsigned FRONT_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           osc_tick,
   input  logic           chain_rst,
   output logic [P_W-1:0] presc,
   output logic           sec_tick
);
   localparam int unsigned TAIL_W = P_W - FRONT_W;

   if (FRONT_W < 3) begin : g_bad_front
      $error("FRONT_W must cover the fast taps");
   end
   if (TAIL_W < 1) begin : g_bad_tail
      $error("prescaler needs at least one tail stage");
   end

   logic [FRONT_W-1:0] front_q;
   logic [TAIL_W-1:0]  tail_q;
   logic               front_carry;

   assign front_carry = osc_tick & (&front_q);
   assign sec_tick    = front_carry & (&tail_q);
   assign presc       = {tail_q, front_q};

   // Front stages: free running, never touched by a load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        front_q <= '0;
      else if (osc_tick) front_q <= front_q + 1'b1;
   end

   // Tail stages: cleared when the counter is loaded
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tail_q <= '0;
      else if (chain_rst)   tail_q <= '0;
      else if (front_carry) tail_q <= tail_q + 1'b1;
   end

   assert_tail_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      chain_rst |=> (presc[P_W-1:FRONT_W] == '0));
   assert_front_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      osc_tick |=> (presc[FRONT_W-1:0] == FRONT_W'($past(presc[FRONT_W-1:0]) + 1'b1)));
   assert_front_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> $stable(presc[FRONT_W-1:0]));
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (load)     count <= load_val;
      else if (sec_tick) count <= count + 1'b1;
   end

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !sec_tick) |=> $stable(count));
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && sec_tick && (&count)) |=> (count == '0));
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));
endmodule

// File: rtl/rtc_sec_port.sv
module rtc_sec_port
   import rtc_sec_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned AW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic             wr_stb,
   input  logic [AW-1:0]    addr,
   input  logic [7:0]       wdata,
   input  logic [CNT_W-1:0] live,
   output logic [7:0]       rdata,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);
   localparam int unsigned BYTES = CNT_W / BYTE_W;
   localparam logic [AW-1:0] TOP_ADDR = AW'(BYTES - 1);

   logic [CNT_W-1:0] snap_q;
   logic [7:0]       snap_b [BYTES];
   logic [7:0]       stage_q [BYTES-1];
   logic             snap_take;

   assign snap_take = rd_stb && (addr == '0);
   assign load      = wr_stb && (addr == TOP_ADDR);

   for (genvar b = 0; b < BYTES; b++) begin : g_snap_bytes
      assign snap_b[b] = snap_q[b*BYTE_W +: BYTE_W];
   end

   // Staging lanes for every byte below the top one
   for (genvar b = 0; b < BYTES - 1; b++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              stage_q[b] <= '0;
         else if (wr_stb && (addr == AW'(b)))     stage_q[b] <= wdata;
      end
      assign load_val[b*BYTE_W +: BYTE_W] = stage_q[b];
   end
   assign load_val[CNT_W-1 -: BYTE_W] = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         snap_q <= '0;
      else if (snap_take) snap_q <= live;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata <= '0;
      else if (snap_take) rdata <= live[7:0];
      else if (rd_stb)    rdata <= snap_b[addr];
   end

   assert_snap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_take |=> $stable(snap_q));
   assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rdata));
   assert_snap_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snap_take |=> (rdata == snap_q[7:0]));
endmodule

// File: rtl/rtc_sec_sqw.sv
module rtc_sec_sqw
   import rtc_sec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_tick,
   input  logic       tap_sec,
   input  logic       tap_4k,
   input  logic       tap_8k,
   input  logic       sq_en,
   input  logic [1:0] sq_sel,
   output logic       sq_out
);
   logic osc_d;
   logic pick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) osc_d <= 1'b0;
      else        osc_d <= osc_tick;
   end

   always_comb begin
      unique case (sq_rate_e'(sq_sel))
         SQ_SEC:  pick = tap_sec;
         SQ_4K:   pick = tap_4k;
         SQ_8K:   pick = tap_8k;
         default: pick = osc_d;
      endcase
   end

   assign sq_out = sq_en & pick;

   always_comb begin
      if (rst_n) assert_quiet_R8: assert (sq_en || !sq_out);
   end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
   import rtc_sec_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned DIV     = 32768,
   parameter int unsigned FRONT_W = 3,
   localparam int unsigned BYTES  = CNT_W / 8,
   localparam int unsigned AW     = $clog2(BYTES),
   localparam int unsigned P_W    = $clog2(DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          osc_tick,
   input  logic          rd_stb,
   input  logic          wr_stb,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   input  logic          sq_en,
   input  logic [1:0]    sq_sel,
   output logic          sq_out
);
   if ((CNT_W % 8) != 0 || CNT_W < 16) begin : g_bad_width
      $error("CNT_W must be a multiple of 8 and at least 16");
   end
   if ((1 << AW) != BYTES) begin : g_bad_bytes
      $error("byte count must be a power of two");
   end
   if ((1 << P_W) != DIV) begin : g_bad_div
      $error("DIV must be a power of two");
   end
   if (P_W <= FRONT_W) begin : g_bad_split
      $error("DIV must exceed the front section");
   end

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] load_val;
   logic             load;
   logic [P_W-1:0]   presc;
   logic             sec_tick;

   rtc_sec_prescaler #(.P_W(P_W), .FRONT_W(FRONT_W)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_tick  (osc_tick),
      .chain_rst (load),
      .presc     (presc),
      .sec_tick  (sec_tick)
   );

   rtc_sec_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .load     (load),
      .load_val (load_val),
      .count    (count)
   );

   rtc_sec_port #(.CNT_W(CNT_W), .AW(AW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb),
      .addr     (addr),
      .wdata    (wdata),
      .live     (count),
      .rdata    (rdata),
      .load     (load),
      .load_val (load_val)
   );

   rtc_sec_sqw u_sqw (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .tap_sec  (presc[P_W-1]),
      .tap_4k   (presc[TAP_4K]),
      .tap_8k   (presc[TAP_8K]),
      .sq_en    (sq_en),
      .sq_sel   (sq_sel),
      .sq_out   (sq_out)
   );

   assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !load) |=> (count == $past(count) + 1'b1));
   assert_sec_low_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sq_en && (sq_sel == SQ_SEC)) |=> (!sq_out || !$stable(sq_sel) || !$stable(sq_en)));
endmodule

// File: tb/rtc_seconds_tb.sv
module rtc_seconds_tb;
   localparam int DIV     = 64;
   localparam int FRONT_W = 3;
   localparam int P_W     = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       sq_en = 1'b0;
   logic [1:0] sq_sel = '0;
   logic       sq_out;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model
   int          m_presc = 0;
   logic [31:0] m_cnt = '0;
   logic [31:0] m_snap = '0;
   logic [7:0]  m_stage [3];
   logic [7:0]  m_rdata = '0;
   logic        m_osc_d = 1'b0;

   always #2 clk = ~clk;

   rtc_seconds #(.CNT_W(32), .DIV(DIV), .FRONT_W(FRONT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rd_stb(rd_stb),
      .wr_stb(wr_stb), .addr(addr), .wdata(wdata), .rdata(rdata),
      .sq_en(sq_en), .sq_sel(sq_sel), .sq_out(sq_out)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic exp_sq();
      logic [P_W-1:0] p;
      p = P_W'(m_presc);
      if (!sq_en) return 1'b0;
      case (sq_sel)
         2'd0: return p[P_W-1];
         2'd1: return p[2];
         2'd2: return p[1];
         default: return m_osc_d;
      endcase
   endfunction

   task automatic step(input logic o, input logic r, input logic w,
                       input logic [1:0] a, input logic [7:0] d);
      logic tick, commit;
      logic [31:0] pre;
      osc_tick = o; rd_stb = r; wr_stb = w; addr = a; wdata = d;
      @(posedge clk);
      #1;
      pre    = m_cnt;
      tick   = o && (m_presc == DIV - 1);
      commit = w && (a == 2'd3);
      if (o) m_presc = (m_presc + 1) % DIV;
      if (commit) m_presc = m_presc % (1 << FRONT_W);
      if (commit) m_cnt = {d, m_stage[2], m_stage[1], m_stage[0]};
      else if (tick) m_cnt = m_cnt + 1;
      if (w && a != 2'd3) m_stage[a] = d;
      if (r) begin
         if (a == 2'd0) begin m_rdata = pre[7:0]; m_snap = pre; end
         else m_rdata = m_snap[a*8 +: 8];
      end
      m_osc_d = o;
      osc_tick = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
      if (r) check(a == 0 ? "R3 live byte" : "R3 snapshot byte", {24'd0, rdata}, {24'd0, m_rdata});
      check((sq_sel == 0) ? "R7 1Hz/R5" : (sq_en ? "R6/R7 tap" : "R8 off"),
            {31'd0, sq_out}, {31'd0, exp_sq()});
   endtask

   task automatic read_all(input logic o);
      for (int k = 0; k < 4; k++) step(o, 1'b1, 1'b0, 2'(k), 8'h00);
   endtask

   task automatic write_all(input logic o, input logic [31:0] v);
      for (int k = 0; k < 4; k++) step(o, 1'b0, 1'b1, 2'(k), v[k*8 +: 8]);
   endtask

   initial begin
      for (int k = 0; k < 3; k++) m_stage[k] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R9: reset state
      check("R9 rdata", {24'd0, rdata}, 32'd0);
      sq_en = 1'b1;
      #0;
      check("R9 sq_out", {31'd0, sq_out}, 32'd0);
      rst_n = 1'b1;
      read_all(1'b0);
      check("R9 count", m_snap, 32'd0);

      // R1/R6/R7: sweep rates, enable settings and enable spacings
      for (int sp = 1; sp <= 3; sp++) begin
         for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
               sq_sel = 2'(s); sq_en = e[0];
               for (int c = 0; c < 90; c++) step((c % sp) == 0, 1'b0, 1'b0, 2'd0, 8'h00);
            end
         end
         read_all(1'b1);   // R1/R3: counter read while enables keep arriving
      end

      // R4: staged bytes leave the count untouched
      sq_sel = 2'd0; sq_en = 1'b1;
      for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b1, 2'(k), 8'hA0 + 8'(k));
      read_all(1'b0);
      check("R4 staging no effect", m_snap, m_cnt);
      step(1'b1, 1'b0, 1'b1, 2'd3, 8'h5C);
      read_all(1'b0);
      check("R4 committed value", m_snap, 32'h5CA2A1A0);

      // R5/R7: loads at many points within a second
      for (int ph = 0; ph < 12; ph++) begin
         for (int c = 0; c < 5 + ph * 7; c++) step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
         for (int s = 1; s < 3; s++) begin
            sq_sel = 2'(s);
            write_all(1'b1, 32'h1000 * ph);
         end
         sq_sel = 2'(ph % 3);
         for (int c = 0; c < DIV + 4; c++) step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
         read_all(1'b0);
         check("R5 tick after load", m_snap, m_cnt);
      end

      // R2: wrap from all ones
      sq_sel = 2'd0;
      write_all(1'b0, 32'hFFFF_FFFF);
      read_all(1'b0);
      check("R2 preload", m_snap, 32'hFFFF_FFFF);
      for (int c = 0; c < DIV; c++) step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
      read_all(1'b0);
      check("R2 wrap to zero", m_snap, 32'd0);

      // R3: snapshot bytes stay frozen across ticks
      write_all(1'b0, 32'h00FF_FFFE);
      for (int c = 0; c < DIV - 8; c++) step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
      step(1'b0, 1'b1, 1'b0, 2'd0, 8'h00);
      for (int c = 0; c < 2 * DIV; c++) step(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
      for (int k = 1; k < 4; k++) step(1'b1, 1'b1, 1'b0, 2'(k), 8'h00);
      check("R3 snapshot frozen", m_snap, 32'h00FF_FFFE);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      done = 1;
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule